// File: doc/BRIEF.md
# Dual-Parity Stripe Syndrome Engine

This block computes the two redundancy chunks of a dual-parity disk stripe for one chunk offset at a time. Data-disk chunks arrive one per beat on a valid/ready input, starting with the highest-numbered data disk and ending with disk 0. In a stripe of N disks, disks 0 to N-3 carry data, disk N-2 holds the XOR parity P and disk N-1 holds the Reed-Solomon syndrome Q over GF(2^8). At least two data disks are expected.

Every byte lane keeps its own P and Q accumulator. For each beat after the first, P takes an XOR of the new byte, and Q is first multiplied by 2 in GF(2^8) and then XORed with the new byte. Q therefore evaluates the data bytes as a polynomial in 2 by Horner's rule. When the beat marked as the last disk is accepted, the finished P and Q chunks move into an output register and both accumulators return to zero, ready for the next offset.

Top module: `pq_syndrome_gen`

## Requirements
- R1: For each byte lane, out_p equals the XOR of that lane's byte over every disk of the chunk.
- R2: For each byte lane, out_q equals the GF(2^8) sum over disks i of d_i times 2^i, where disk 0 is the last beat and the highest disk the first (field polynomial x^8+x^4+x^3+x^2+1).
- R3: Doubling a byte shifts it left one bit, drops the carry, and XORs 0x1D when the old bit 7 was set; each of the LANES bytes (byte k at in_data[8k+7:8k]) doubles on its own with no carry into a neighbour.
- R4: A beat with in_first=1 loads both accumulators with its data, discarding anything gathered before it.
- R5: After a beat with in_last=1 is accepted, both accumulators are zero, so a following chunk with no in_first marker still yields the correct result.
- R6: While out_valid=1 and out_ready=0, out_valid stays high and out_p, out_q stay unchanged.
- R7: in_ready is 0 while a result is pending; beats offered then are not taken and change neither the pending result nor the accumulators.
- R8: After reset, out_valid=0, in_ready=1 and the accumulators are zero.
- R9: out_valid rises on the clock edge that accepts the in_last beat; it falls on the edge where out_ready=1 is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A data-disk chunk is offered |
| in_ready | output | 1 | Block can take a chunk |
| in_data | input | 8*LANES | Chunk bytes, byte k in bits 8k+7:8k |
| in_first | input | 1 | Beat is the highest data disk |
| in_last | input | 1 | Beat is data disk 0 |
| out_valid | output | 1 | Finished P and Q available |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | 8*LANES | XOR parity chunk |
| out_q | output | 8*LANES | GF(2^8) syndrome chunk |

## Verification
Random stripes of two, five and sixteen disks set the XOR parity against a bench model built on a general bit-serial field multiply, which separates a correct Horner order from a reversed one. A single byte 0x80 or 0x40 placed in one lane shows whether the 0x1D reduction fires only on a set top bit and whether any carry leaks into the next lane. A restart with a second first marker, a chunk sent without a first marker, and beats offered while a result waits tell apart loading, clearing and back-pressure.

// File: rtl/pq_syn_pkg.sv
// Package: shared constants and the GF(2^8) doubling used by every lane.
// Assumes the field polynomial x^8+x^4+x^3+x^2+1 (low byte 0x1D).
package pq_syn_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  GF_RED_LOW  = 8'h1D;

    // Multiply one byte by 2 in GF(2^8): the sign test gives a full mask.
    function automatic logic [7:0] gf_times2(input logic [7:0] b);
        logic [7:0] mask;
        mask = ($signed(b) < 8'sd0) ? 8'hFF : 8'h00;
        return {b[6:0], 1'b0} ^ (mask & GF_RED_LOW);
    endfunction

endpackage

// File: rtl/pq_lane.sv
// Module: one byte lane of the syndrome engine.
// Holds the P and Q accumulators for a single byte position, offers the
// next values combinationally, and clears both once the last disk is taken.
// Assumes beats arrive highest data disk first.
module pq_lane
    import pq_syn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               first,
    input  logic               last,
    input  logic [BYTE_W-1:0]  din,
    output logic [BYTE_W-1:0]  p_next,
    output logic [BYTE_W-1:0]  q_next
);

    logic [BYTE_W-1:0] acc_p;
    logic [BYTE_W-1:0] acc_q;

    // Next accumulator values: a first beat seeds, later beats fold in.
    always_comb begin
        if (first) begin
            p_next = din;
            q_next = din;
        end else begin
            p_next = acc_p ^ din;
            q_next = gf_times2(acc_q) ^ din;
        end
    end

    // Accumulator update, returned to zero after the last disk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_p <= '0;
            acc_q <= '0;
        end else if (take) begin
            if (last) begin
                acc_p <= '0;
                acc_q <= '0;
            end else begin
                acc_p <= p_next;
                acc_q <= q_next;
            end
        end
    end

    // R5: nothing survives a finished chunk
    a_r5_clear_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        take && last |=> (acc_p == '0) && (acc_q == '0));

    // R4: a first beat replaces both accumulators by its data
    a_r4_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
        take && first && !last |=> (acc_p == $past(din)) && (acc_q == $past(din)));

    // R7: no beat taken means no change
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(acc_p) && $stable(acc_q));

endmodule

// File: rtl/pq_hold.sv
// Module: output register of the syndrome engine.
// Captures the finished P and Q chunks and keeps them until the consumer
// takes them. Assumes the producer never loads while a result is pending.
module pq_hold #(
    parameter int W = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  p_in,
    input  logic [W-1:0]  q_in,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [W-1:0]  out_p,
    output logic [W-1:0]  out_q
);

    // Result capture and release on the output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_p     <= '0;
            out_q     <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_p     <= p_in;
            out_q     <= q_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6: a result waits unchanged until taken
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_q));

    // R7: the producer never overwrites a pending result
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !load);

    // R9: release on the accepting edge
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !load |=> !out_valid);

endmodule

// File: rtl/pq_syndrome_gen.sv
// Module: dual-parity stripe syndrome engine (top).
// Streams data-disk chunks, highest disk first, through LANES independent
// byte lanes and presents the finished P and Q chunks on a held output.
// Assumes at least two data disks per chunk, marked by in_first/in_last.
module pq_syndrome_gen
    import pq_syn_pkg::*;
#(
    parameter int LANES = 64,
    localparam int W    = LANES * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic          in_first,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_p,
    output logic [W-1:0]  out_q
);

    logic          take;
    logic          finish;
    logic [W-1:0]  p_next;
    logic [W-1:0]  q_next;

    // Input accepted only when no result is waiting.
    assign in_ready = !out_valid;
    assign take     = in_valid && in_ready;
    assign finish   = take && in_last;

    // One lane per byte, all alike.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pq_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take),
            .first  (in_first),
            .last   (in_last),
            .din    (in_data[k*BYTE_W +: BYTE_W]),
            .p_next (p_next[k*BYTE_W +: BYTE_W]),
            .q_next (q_next[k*BYTE_W +: BYTE_W])
        );
    end

    pq_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (finish),
        .p_in      (p_next),
        .q_in      (q_next),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_p     (out_p),
        .out_q     (out_q)
    );

    // R9: the result follows the last beat by one edge
    a_r9_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> out_valid);

    // R7: back-pressure while a result waits
    a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !in_ready);

endmodule

// File: tb/tb_pq_syndrome_gen.sv
module tb_pq_syndrome_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 64;
    localparam int W          = LANES * 8;
    localparam int MAXD       = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_first, in_last, out_ready;
    logic          in_ready, out_valid;
    logic [W-1:0]  in_data, out_p, out_q;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    logic [W-1:0] dk [MAXD];

    always #(CLK_PERIOD/2) clk = ~clk;

    pq_syndrome_gen #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_p(out_p), .out_q(out_q)
    );

    // General GF(2^8) product, bit-serial, polynomial 0x11D.
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [8:0] t;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            t = {a, 1'b0};
            if (t[8]) t ^= 9'h11D;
            a = t[7:0];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] model_p(input int n);
        logic [W-1:0] r = '0;
        for (int i = 0; i < n; i++) r ^= dk[i];
        return r;
    endfunction

    function automatic logic [W-1:0] model_q(input int n);
        logic [W-1:0] r = '0;
        logic [7:0] c = 8'h01;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < LANES; k++)
                r[k*8 +: 8] ^= gmul(dk[i][k*8 +: 8], c);
            c = gmul(c, 8'h02);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++)
            for (int j = 0; j < W/32; j++) dk[i][j*32 +: 32] = $urandom();
    endtask

    task automatic beat(input logic [W-1:0] d, input logic f, input logic l);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = d; in_first = f; in_last = l; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_chunk(input int n, input bit use_first);
        for (int i = n - 1; i >= 0; i--)
            beat(dk[i], use_first && (i == n - 1), i == 0);
        chk1("R9 out_valid after last beat", out_valid, 1'b1);
    endtask

    task automatic take_result(input string tag, input int n);
        @(negedge clk);
        chk({tag, " R1 P"}, out_p, model_p(n));
        chk({tag, " R2 Q"}, out_q, model_q(n));
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
        chk1({tag, " R9 released"}, out_valid, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk1("R8 out_valid", out_valid, 1'b0);
        chk1("R8 in_ready", in_ready, 1'b1);
    endtask

    task automatic t_random(input int n);
        fill(n);
        send_chunk(n, 1);
        take_result($sformatf("random n=%0d", n), n);
    endtask

    task automatic t_lane_double;
        logic [W-1:0] e;
        dk[0] = '0; dk[1] = '0; dk[1][5*8 +: 8] = 8'h80;
        send_chunk(2, 1);
        e = '0; e[5*8 +: 8] = 8'h1D;
        @(negedge clk);
        chk("R3 0x80 doubles to 0x1D in lane 5 only", out_q, e);
        take_result("R3 top set", 2);
        dk[1] = '0; dk[1][9*8 +: 8] = 8'h40;
        send_chunk(2, 1);
        e = '0; e[9*8 +: 8] = 8'h80;
        @(negedge clk);
        chk("R3 0x40 doubles to 0x80 without reduction", out_q, e);
        take_result("R3 top clear", 2);
    endtask

    task automatic t_backpressure;
        logic [W-1:0] hp, hq;
        fill(3);
        send_chunk(3, 1);
        @(negedge clk);
        hp = out_p; hq = out_q;
        for (int c = 0; c < 3; c++) begin
            in_data = {LANES{8'hA5}}; in_first = 1'b1; in_last = 1'b1; in_valid = 1'b1;
            @(negedge clk);
            chk1("R7 in_ready low while pending", in_ready, 1'b0);
            chk1("R6 out_valid held", out_valid, 1'b1);
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        chk("R6 P held", out_p, hp);
        chk("R6 Q held", out_q, hq);
        take_result("R7 pending result intact", 3);
        fill(4);
        send_chunk(4, 0);
        take_result("R7 accumulators untouched", 4);
    endtask

    task automatic t_restart;
        fill(3);
        beat(~dk[2], 1, 0);
        beat(~dk[1], 0, 0);
        send_chunk(3, 1);
        take_result("R4 restart on first marker", 3);
    endtask

    task automatic t_clear;
        fill(5);
        send_chunk(5, 1);
        take_result("R5 seed chunk", 5);
        fill(5);
        send_chunk(5, 0);
        take_result("R5 no first marker after clear", 5);
    endtask

    task automatic t_full_ones;
        for (int i = 0; i < MAXD; i++) dk[i] = '1;
        send_chunk(MAXD, 1);
        take_result("R2 sixteen disks of 0xFF", MAXD);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        out_ready = 1'b0; in_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_random(2);
        t_random(5);
        t_lane_double();
        t_backpressure();
        t_restart();
        t_clear();
        t_full_ones();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule